// File: doc/BRIEF.md
# Segment Register Load Unit

This block carries out a request to load a 16-bit selector into one of six segment registers, or into the local descriptor table register. It splits the selector into a table index, a table-select bit and a requested privilege level. It picks the global or the local table and checks the index against that table's limit. It then reads the 8-byte descriptor over a 32-bit memory read port in two beats. Architectural checks follow, after which the unit either fills the target's hidden descriptor cache or reports a fault with an error code.

The global table register is written directly with a base and a byte limit. The local table register is loaded through the same fetch path as a seventh target, and its cached base and limit then serve selectors that choose the local table. A read port returns any cached entry. The caller pulses a request, watches busy and waits for a single-cycle done, which comes with the fault result.

Top module: `seg_load_unit`

## Requirements
- R1: A selector carries the table index in bits 15:3, the table-select bit in bit 2 (0 global, 1 local) and the requested privilege level in bits 1:0. The descriptor is read as two words: the low word at table base + index*8, then the high word at that address + 4.
- R2: A pulse on gdt_wr loads the global table base and its 16-bit byte limit, which show on gdt_base and gdt_limit from the next cycle. Both reset to zero.
- R3: If index*8+7 exceeds the chosen table's limit, or the local table is chosen while its cache is invalid, the load ends in a general-protection fault with no memory read.
- R4: Target code 1 (the code segment) and code 7 are refused with an invalid-opcode fault, with no memory read and no cache change. The fault comes on the second cycle after the request is taken.
- R5: A descriptor that passes the type check but has its present flag (high word bit 15) clear gives a segment-not-present fault.
- R6: A load of the stack segment (target 2) needs S=1 (high word bit 12), type bit 3 clear (data) and type bit 1 set (writable), otherwise a general-protection fault. The type is in high word bits 11:8.
- R7: A load of ES, DS, FS or GS (targets 0, 3, 4, 5) needs S=1 and must not name an execute-only code segment (type bit 3 set with bit 1 clear), otherwise a general-protection fault.
- R8: A load of the local table register (target 6) with the table-select bit set is a general-protection fault with no memory read. Its descriptor must have S=0 and type 2, otherwise a general-protection fault. After a successful load, local-table selectors fetch from its base and are checked against its limit.
- R9: A null selector (index 0, table-select 0) loaded into targets 0, 3, 4, 5 or 6 gives no fault and no memory read, and leaves the entry invalid with the selector recorded. Loaded into the stack segment, it gives a general-protection fault with error code 0.
- R10: fault_kind encodes 0 none, 1 general protection, 2 not present and 3 invalid opcode. fault_code is the selector with bits 1:0 cleared, and fault is high only together with done when fault_kind is not 0.
- R11: After a successful load, the read port for that target (codes 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS, 6 local table) shows valid, the selector, the 32-bit base, the effective limit ({limit,12'hFFF} when G is set, otherwise the zero-extended 20-bit limit), the DPL, {S,type} and the flags {G, D/B, L, AVL}. A faulted load leaves every entry unchanged.
- R12: busy is high from the cycle after a request is taken until the end of the one-cycle done pulse. Requests made while busy are ignored and cause no second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gdt_wr | input | 1 | Write strobe for the global table register |
| gdt_base_in | input | 32 | New global table base |
| gdt_limit_in | input | 16 | New global table byte limit |
| gdt_base | output | 32 | Current global table base |
| gdt_limit | output | 16 | Current global table limit |
| req_valid | input | 1 | Load request strobe |
| req_target | input | 3 | Target register code |
| req_sel | input | 16 | Selector to load |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Load ended with a fault (valid with done) |
| fault_kind | output | 2 | Fault class |
| fault_code | output | 16 | Error code |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rd_target | input | 3 | Cache entry to show on the read port |
| rd_valid | output | 1 | Entry holds a usable descriptor |
| rd_sel | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached effective limit |
| rd_dpl | output | 2 | Cached descriptor privilege level |
| rd_sys_type | output | 5 | Cached {S, type} |
| rd_flags | output | 4 | Cached {G, D/B, L, AVL} |

## Verification
The main sweep runs every target against all 32 values of {S, type} with the present flag both clear and set. This separates the per-target type rules from the presence rule and shows that the type check comes first. A second sweep runs every global-table limit from 0 to 63 against every index from 1 to 7, which places the bounds boundary at each position and checks that no read is issued past it. Directed sequences then cover local-table selection before and after loading the local table register, null selectors per target, and a request that arrives while busy. Read addresses and the cached entries are compared against a model after every load.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEL_W    = 16;
    localparam int ADDR_W   = 32;
    localparam int IDX_W    = 13;
    localparam int TGT_W    = 3;
    localparam int NUM_ENT  = 7;
    localparam int WORD_OFS = 4;

    localparam logic [TGT_W-1:0] TGT_ES  = 3'd0;
    localparam logic [TGT_W-1:0] TGT_CS  = 3'd1;
    localparam logic [TGT_W-1:0] TGT_SS  = 3'd2;
    localparam logic [TGT_W-1:0] TGT_LDT = 3'd6;
    localparam logic [TGT_W-1:0] TGT_BAD = 3'd7;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2,
        FLT_UD   = 2'd3
    } fault_e;

    typedef struct packed {
        logic              valid;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [1:0]        dpl;
        logic              s;
        logic [3:0]        typ;
        logic              g;
        logic              db;
        logic              lng;
        logic              avl;
    } seg_ent_t;

    // Build a cache entry from the two descriptor words.
    function automatic seg_ent_t unpack_desc(input logic [SEL_W-1:0] sel,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi);
        seg_ent_t e;
        logic [19:0] raw;
        raw     = {hi[19:16], lo[15:0]};
        e.valid = 1'b1;
        e.sel   = sel;
        e.base  = {hi[31:24], hi[7:0], lo[31:16]};
        e.g     = hi[23];
        e.db    = hi[22];
        e.lng   = hi[21];
        e.avl   = hi[20];
        e.dpl   = hi[14:13];
        e.s     = hi[12];
        e.typ   = hi[11:8];
        e.limit = hi[23] ? {raw, 12'hFFF} : {12'd0, raw};
        return e;
    endfunction

    // Per-target descriptor type rule.
    function automatic logic type_ok(input logic [TGT_W-1:0] tgt,
                                     input logic s, input logic [3:0] typ);
        if (tgt == TGT_SS)       return s && !typ[3] && typ[1];
        else if (tgt == TGT_LDT) return !s && (typ == 4'h2);
        else                     return s && (!typ[3] || typ[1]);
    endfunction

endpackage

// File: rtl/seg_gdtr.sv
module seg_gdtr
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [15:0]       limit_in,
    output logic [ADDR_W-1:0] base,
    output logic [15:0]       limit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            limit <= '0;
        end else if (wr) begin
            base  <= base_in;
            limit <= limit_in;
        end
    end
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
    import seg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ENT-1:0] wr_en,
    input  seg_ent_t           wr_data,
    input  logic [TGT_W-1:0]   rd_idx,
    output seg_ent_t           rd_ent,
    output seg_ent_t           ldt_ent
);
    seg_ent_t ent [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)           ent[i] <= '0;
            else if (wr_en[i]) ent[i] <= wr_data;
        end
    end

    always_comb begin
        rd_ent = '0;
        for (int i = 0; i < NUM_ENT; i++)
            if (rd_idx == 3'(i)) rd_ent = ent[i];
    end

    assign ldt_ent = ent[NUM_ENT-1];

    // R11
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));
    // R4
    cs_never_written_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en[TGT_CS]);
    // R4
    cs_stays_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        !ent[TGT_CS].valid);
endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
    import seg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [TGT_W-1:0]   req_target,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic [ADDR_W-1:0]  gdt_base,
    input  logic [15:0]        gdt_limit,
    input  seg_ent_t           ldt_ent,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [1:0]         fault_kind,
    output logic [SEL_W-1:0]   fault_code,
    output logic [NUM_ENT-1:0] wr_en,
    output seg_ent_t           wr_data
);
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_RD0, S_W0, S_RD1, S_W1, S_CHK, S_FIN
    } st_e;

    st_e               st;
    logic [TGT_W-1:0]  tgt_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q, hi_q;
    fault_e            kind_q;

    logic [IDX_W-1:0]  idx;
    logic              ti, is_null, tbl_ok;
    logic [ADDR_W-1:0] tbl_base, tbl_lim, end_ofs;
    fault_e            pre_fault, chk_fault;
    seg_ent_t          desc;

    assign idx      = sel_q[SEL_W-1:3];
    assign ti       = sel_q[2];
    assign is_null  = (idx == '0) && !ti;
    assign tbl_ok   = !ti || ldt_ent.valid;
    assign tbl_base = ti ? ldt_ent.base  : gdt_base;
    assign tbl_lim  = ti ? ldt_ent.limit : {16'd0, gdt_limit};
    assign end_ofs  = {16'd0, idx, 3'b111};
    assign desc     = unpack_desc(sel_q, lo_q, hi_q);

    always_comb begin
        if (tgt_q == TGT_CS || tgt_q == TGT_BAD)  pre_fault = FLT_UD;
        else if (tgt_q == TGT_LDT && ti)          pre_fault = FLT_GP;
        else if (is_null)                         pre_fault = (tgt_q == TGT_SS) ? FLT_GP : FLT_NONE;
        else if (!tbl_ok || end_ofs > tbl_lim)    pre_fault = FLT_GP;
        else                                      pre_fault = FLT_NONE;
    end

    always_comb begin
        if (!type_ok(tgt_q, desc.s, desc.typ)) chk_fault = FLT_GP;
        else if (!hi_q[15])                    chk_fault = FLT_NP;
        else                                   chk_fault = FLT_NONE;
    end

    always_comb begin
        wr_en   = '0;
        wr_data = desc;
        if (st == S_PRE && pre_fault == FLT_NONE && is_null) begin
            wr_data     = '0;
            wr_data.sel = sel_q;
        end
        for (int i = 0; i < NUM_ENT; i++) begin
            if (tgt_q == 3'(i) &&
                ((st == S_PRE && pre_fault == FLT_NONE && is_null) ||
                 (st == S_CHK && chk_fault == FLT_NONE)))
                wr_en[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            tgt_q  <= '0;
            sel_q  <= '0;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            kind_q <= FLT_NONE;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    tgt_q <= req_target;
                    sel_q <= req_sel;
                    st    <= S_PRE;
                end
                S_PRE: begin
                    kind_q <= pre_fault;
                    if (pre_fault != FLT_NONE || is_null) st <= S_FIN;
                    else begin
                        addr_q <= tbl_base + {16'd0, idx, 3'b000};
                        st     <= S_RD0;
                    end
                end
                S_RD0: st <= S_W0;
                S_W0: if (mem_rvalid) begin
                    lo_q <= mem_rdata;
                    st   <= S_RD1;
                end
                S_RD1: st <= S_W1;
                S_W1: if (mem_rvalid) begin
                    hi_q <= mem_rdata;
                    st   <= S_CHK;
                end
                S_CHK: begin
                    kind_q <= chk_fault;
                    st     <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign mem_rd     = (st == S_RD0) || (st == S_RD1);
    assign mem_addr   = (st == S_RD1) ? addr_q + ADDR_W'(WORD_OFS) : addr_q;
    assign busy       = (st != S_IDLE);
    assign done       = (st == S_FIN);
    assign fault      = done && (kind_q != FLT_NONE);
    assign fault_kind = kind_q;
    assign fault_code = {sel_q[SEL_W-1:2], 2'b00};

    // R12
    read_inside_op_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);
    // R12
    done_releases_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R12
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(sel_q) && $stable(tgt_q));
    // R4
    cs_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (tgt_q != TGT_CS && tgt_q != TGT_BAD));
    // R8
    ldt_local_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !(tgt_q == TGT_LDT && sel_q[2]));
    // R10
    fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (done && fault_kind != 2'd0));
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gdt_wr,
    input  logic [31:0] gdt_base_in,
    input  logic [15:0] gdt_limit_in,
    output logic [31:0] gdt_base,
    output logic [15:0] gdt_limit,
    input  logic        req_valid,
    input  logic [2:0]  req_target,
    input  logic [15:0] req_sel,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic [1:0]  fault_kind,
    output logic [15:0] fault_code,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic [2:0]  rd_target,
    output logic        rd_valid,
    output logic [15:0] rd_sel,
    output logic [31:0] rd_base,
    output logic [31:0] rd_limit,
    output logic [1:0]  rd_dpl,
    output logic [4:0]  rd_sys_type,
    output logic [3:0]  rd_flags
);
    logic [NUM_ENT-1:0] wr_en;
    seg_ent_t           wr_data, rd_ent, ldt_ent;

    seg_gdtr u_gdtr (
        .clk(clk), .rst(rst), .wr(gdt_wr),
        .base_in(gdt_base_in), .limit_in(gdt_limit_in),
        .base(gdt_base), .limit(gdt_limit)
    );

    seg_fetch_fsm u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_target(req_target), .req_sel(req_sel),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit), .ldt_ent(ldt_ent),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault),
        .fault_kind(fault_kind), .fault_code(fault_code),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    seg_cache_bank u_cache (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_idx(rd_target), .rd_ent(rd_ent), .ldt_ent(ldt_ent)
    );

    assign rd_valid    = rd_ent.valid;
    assign rd_sel      = rd_ent.sel;
    assign rd_base     = rd_ent.base;
    assign rd_limit    = rd_ent.limit;
    assign rd_dpl      = rd_ent.dpl;
    assign rd_sys_type = {rd_ent.s, rd_ent.typ};
    assign rd_flags    = {rd_ent.g, rd_ent.db, rd_ent.lng, rd_ent.avl};
endmodule

// File: tb/seg_load_unit_test.sv
module seg_load_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gdt_wr = 1'b0;
    logic [31:0] gdt_base_in = '0;
    logic [15:0] gdt_limit_in = '0;
    logic [31:0] gdt_base;
    logic [15:0] gdt_limit;
    logic        req_valid = 1'b0;
    logic [2:0]  req_target = '0;
    logic [15:0] req_sel = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  rd_target = '0;
    logic        rd_valid;
    logic [15:0] rd_sel;
    logic [31:0] rd_base, rd_limit;
    logic [1:0]  rd_dpl;
    logic [4:0]  rd_sys_type;
    logic [3:0]  rd_flags;

    seg_load_unit uut (.*);

    always #10 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc_cnt = 0;
    bit finished = 0;

    logic [31:0] mem [64];
    int rd_cnt = 0, lat = 0, pend_cnt = 0;
    bit pend = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] addr_log [2];

    // model of cache entries
    logic        e_valid [7];
    logic [15:0] e_sel   [7];
    logic [31:0] e_base  [7];
    logic [31:0] e_lim   [7];
    logic [1:0]  e_dpl   [7];
    logic [4:0]  e_st    [7];
    logic [3:0]  e_fl    [7];

    // memory responder, acts away from the active edge
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend && pend_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[pend_addr[7:2]];
            pend = 0;
        end else if (pend) pend_cnt--;
        if (mem_rd) begin
            addr_log[rd_cnt % 2] = mem_addr;
            rd_cnt++;
            pend = 1; pend_addr = mem_addr; pend_cnt = lat;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000 && !finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R12 actual=%0d expected=%0d", cyc_cnt, 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] d_lo(input logic [31:0] b, input logic [19:0] l);
        return {b[15:0], l[15:0]};
    endfunction

    function automatic logic [31:0] d_hi(input logic [31:0] b, input logic [19:0] l,
            input logic [3:0] fl, input logic p, input logic [1:0] dpl, input logic [4:0] st);
        return {b[31:24], fl, l[19:16], p, dpl, st, b[23:16]};
    endfunction

    function automatic logic [1:0] exp_kind(input logic [2:0] t, input logic [4:0] st, input logic p);
        logic ok;
        if (t == 3'd1 || t == 3'd7) return 2'd3;
        if (t == 3'd2)      ok = st[4] && !st[3] && st[1];
        else if (t == 3'd6) ok = !st[4] && st[3:0] == 4'h2;
        else                ok = st[4] && (!st[3] || st[1]);
        if (!ok) return 2'd1;
        if (!p)  return 2'd2;
        return 2'd0;
    endfunction

    task automatic set_gdt(input logic [31:0] b, input logic [15:0] l);
        gdt_wr = 1; gdt_base_in = b; gdt_limit_in = l;
        @(negedge clk);
        gdt_wr = 0;
    endtask

    task automatic do_load(input logic [2:0] t, input logic [15:0] s,
                           output logic [1:0] k, output logic [15:0] c,
                           output int reads, output int cyc);
        int r0;
        r0 = rd_cnt;
        req_valid = 1; req_target = t; req_sel = s;
        @(negedge clk);
        req_valid = 0; cyc = 1;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        k = fault_kind; c = fault_code; reads = rd_cnt - r0;
        chk("R12 done seen", {31'd0, done}, 32'd1);
        @(negedge clk);
    endtask

    task automatic check_ent(input logic [2:0] t, input string rq);
        rd_target = t; #1;
        chk(rq, {31'd0, rd_valid}, {31'd0, e_valid[t]});
        chk(rq, {16'd0, rd_sel}, {16'd0, e_sel[t]});
        if (e_valid[t]) begin
            chk(rq, rd_base, e_base[t]);
            chk(rq, rd_limit, e_lim[t]);
            chk(rq, {23'd0, rd_dpl, rd_sys_type, rd_flags}, {23'd0, e_dpl[t], e_st[t], e_fl[t]});
        end
    endtask

    task automatic model_set(input logic [2:0] t, input logic [15:0] s, input logic [31:0] b,
            input logic [19:0] l, input logic [3:0] fl, input logic [1:0] dpl, input logic [4:0] st);
        e_valid[t] = 1; e_sel[t] = s; e_base[t] = b;
        e_lim[t] = fl[3] ? {l, 12'hFFF} : {12'd0, l};
        e_dpl[t] = dpl; e_st[t] = st; e_fl[t] = fl;
    endtask

    task automatic put_desc(input int idx_word, input logic [31:0] b, input logic [19:0] l,
            input logic [3:0] fl, input logic p, input logic [1:0] dpl, input logic [4:0] st);
        mem[idx_word]     = d_lo(b, l);
        mem[idx_word + 1] = d_hi(b, l, fl, p, dpl, st);
    endtask

    initial begin
        logic [1:0]  k, ek;
        logic [15:0] c, s;
        int reads, cyc, dones;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 7; i++) begin
            e_valid[i] = 0; e_sel[i] = 0; e_base[i] = 0; e_lim[i] = 0;
            e_dpl[i] = 0; e_st[i] = 0; e_fl[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // reset state: R2, R12, R11
        chk("R2 reset base", gdt_base, 32'd0);
        chk("R2 reset limit", {16'd0, gdt_limit}, 32'd0);
        chk("R12 reset busy/done/mem_rd", {29'd0, busy, done, mem_rd}, 32'd0);
        for (int t = 0; t < 7; t++) check_ent(3'(t), "R11 reset entry");

        // R2 table register load
        set_gdt(32'h0000_0000, 16'h003F);
        chk("R2 gdt base", gdt_base, 32'd0);
        chk("R2 gdt limit", {16'd0, gdt_limit}, 32'h3F);

        // Sweep: targets x {S,type} x present (R4..R8, R10, R11, R1)
        for (int t = 0; t < 7; t++) begin
            for (int st = 0; st < 32; st++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [7:0] i8;
                    logic [31:0] b;
                    logic [19:0] l;
                    logic [3:0] fl;
                    i8 = 8'(t * 64 + st * 2 + p);
                    b  = {i8 ^ 8'hA5, i8, 8'h3C, ~i8};
                    l  = {i8[3:0], i8 ^ 8'h5A, i8};
                    fl = {i8[0], i8[3], i8[5], i8[6]};
                    put_desc(6, b, l, fl, p[0], i8[2:1], 5'(st));
                    lat = st % 3;
                    s = {13'd3, 1'b0, i8[1:0]};
                    do_load(3'(t), s, k, c, reads, cyc);
                    ek = exp_kind(3'(t), 5'(st), p[0]);
                    chk("R5 R6 R7 R8 fault kind", {30'd0, k}, {30'd0, ek});
                    if (ek != 0) chk("R10 error code", {16'd0, c}, {16'd0, s & 16'hFFFC});
                    if (t == 1) begin
                        chk("R4 no read for CS", reads, 0);
                        chk("R4 fault latency", cyc, 2);
                    end else begin
                        chk("R1 two reads", reads, 2);
                        chk("R1 low word addr", addr_log[0], 32'h18);
                        chk("R1 high word addr", addr_log[1], 32'h1C);
                    end
                    if (ek == 0) model_set(3'(t), s, b, l, fl, i8[2:1], 5'(st));
                    check_ent(3'(t), "R11 entry after load");
                end
            end
        end

        // Invalid target code 7 (R4)
        do_load(3'd7, 16'h0018, k, c, reads, cyc);
        chk("R4 code 7 UD", {30'd0, k}, 32'd3);
        chk("R4 code 7 no read", reads, 0);

        // Bounds sweep (R3): all GDT entries writable data
        for (int x = 0; x < 8; x++)
            put_desc(x * 2, 32'h1000 * x, 20'h00FFF, 4'b0100, 1'b1, 2'd0, 5'h12);
        lat = 0;
        for (int lim = 0; lim < 64; lim++) begin
            set_gdt(32'h0, 16'(lim));
            for (int x = 1; x < 8; x++) begin
                s = {13'(x), 1'b0, 2'b11};
                do_load(3'd3, s, k, c, reads, cyc);
                if (x * 8 + 7 > lim) begin
                    chk("R3 over limit GP", {30'd0, k}, 32'd1);
                    chk("R3 no read over limit", reads, 0);
                    chk("R10 code", {16'd0, c}, {16'd0, s & 16'hFFFC});
                end else begin
                    chk("R3 within limit ok", {30'd0, k}, 32'd0);
                    chk("R1 addr by index", addr_log[0], 32'(x * 8));
                    model_set(3'd3, s, 32'h1000 * x, 20'h00FFF, 4'b0100, 2'd0, 5'h12);
                end
            end
        end
        check_ent(3'd3, "R11 DS after bounds sweep");

        // Local table (R8, R3)
        set_gdt(32'h0, 16'h003F);
        do_load(3'd6, 16'h0000, k, c, reads, cyc);   // null LDTR: invalidates (R9)
        chk("R9 null LDTR no fault", {30'd0, k}, 32'd0);
        e_valid[6] = 0; e_sel[6] = 16'h0000;
        check_ent(3'd6, "R9 LDTR invalid");
        do_load(3'd0, 16'h0014, k, c, reads, cyc);
        chk("R3 local table invalid GP", {30'd0, k}, 32'd1);
        chk("R3 no read when invalid", reads, 0);
        put_desc(10, 32'h0000_0080, 20'h0001F, 4'b0000, 1'b1, 2'd0, 5'h02);
        do_load(3'd6, 16'h002C, k, c, reads, cyc);
        chk("R8 LDTR TI set GP", {30'd0, k}, 32'd1);
        chk("R8 LDTR TI no read", reads, 0);
        do_load(3'd6, 16'h0028, k, c, reads, cyc);
        chk("R8 LDTR load ok", {30'd0, k}, 32'd0);
        model_set(3'd6, 16'h0028, 32'h80, 20'h1F, 4'b0000, 2'd0, 5'h02);
        check_ent(3'd6, "R8 LDTR entry");
        put_desc(32 + 6, 32'hCAFE_0000, 20'h00123, 4'b0100, 1'b1, 2'd2, 5'h13);
        do_load(3'd0, 16'h001E, k, c, reads, cyc);   // LDT idx 3, end 31 == limit
        chk("R8 local entry at limit ok", {30'd0, k}, 32'd0);
        chk("R8 local addr", addr_log[0], 32'h98);
        model_set(3'd0, 16'h001E, 32'hCAFE_0000, 20'h00123, 4'b0100, 2'd2, 5'h13);
        check_ent(3'd0, "R8 ES from local table");
        do_load(3'd0, 16'h0024, k, c, reads, cyc);   // LDT idx 4 over limit
        chk("R3 local over limit GP", {30'd0, k}, 32'd1);
        chk("R3 local no read", reads, 0);
        check_ent(3'd0, "R11 ES unchanged after fault");

        // Null selectors (R9)
        do_load(3'd4, 16'h0003, k, c, reads, cyc);
        chk("R9 null FS no fault", {30'd0, k}, 32'd0);
        chk("R9 null FS no read", reads, 0);
        e_valid[4] = 0; e_sel[4] = 16'h0003;
        check_ent(3'd4, "R9 FS invalid");
        do_load(3'd2, 16'h0002, k, c, reads, cyc);
        chk("R9 null SS GP", {30'd0, k}, 32'd1);
        chk("R9 null SS code", {16'd0, c}, 32'd0);
        check_ent(3'd2, "R9 SS unchanged");

        // Request while busy is ignored (R12)
        dones = 0;
        req_valid = 1; req_target = 3'd5; req_sel = 16'h0010;
        @(negedge clk);
        chk("R12 busy after request", {31'd0, busy}, 32'd1);
        req_target = 3'd4; req_sel = 16'h0020;
        cyc = 0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        req_valid = 0;
        if (done) dones++;
        @(negedge clk);
        chk("R12 busy low after done", {31'd0, busy}, 32'd0);
        repeat (3) begin if (done) dones++; @(negedge clk); end
        chk("R12 single done", dones, 1);
        model_set(3'd5, 16'h0010, 32'h2000, 20'h00FFF, 4'b0100, 2'd0, 5'h12);
        check_ent(3'd5, "R12 GS loaded");
        check_ent(3'd4, "R12 FS untouched");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule